// File: doc/BRIEF.md
# Scanline Buffer Video Decoupler

This block sits between a CPU that produces video by writing bytes to an output port and the video output pins. The CPU can run at any clock rate. The block captures one line of pixels per CPU scanline into a ping-pong pair of line stores. A separate pixel-clock domain replays the most recent complete line under its own horizontal and vertical timing.

Because of this split, the sync pulses keep a fixed effective pixel rate however fast the CPU runs. The CPU also has to produce a given line only once: the read side shows each captured line 1 to 4 times, as set by a repeat selector.

Each stored pixel index goes out in one of two ways. With the palette enabled, it passes through a 64-entry table of 12-bit colours. With the palette disabled, each 2-bit colour field is widened by bit duplication. Only two single-bit flags cross between the clock domains, each through a two-flop synchroniser.

Top module: `scanline_decoupler`

## Requirements
- R1: Each output line lasts LINE_PIX+H_FP+H_SYNC+H_BP pixel ticks (defaults 160+4+24+12 = 200). `hsync_n` is low for exactly H_SYNC ticks, starting at tick LINE_PIX+H_FP of the line.
- R2: Each frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (defaults 480+10+2+33 = 525). `vsync_n` is low for the V_SYNC whole lines that begin at line V_VIS+V_FP.
- R3: `rgb` is zero at every tick outside the visible window, which is tick < LINE_PIX and line < V_VIS.
- R4: A CPU write byte carries vertical sync in bit 7, horizontal sync in bit 6 and the colour index in bits 5:0; both syncs are active low. A write whose bit 6 is 0 after a write whose bit 6 was 1 starts a new capture line at pixel 0. After that, only writes with bits 7 and 6 both 1 are stored, in order, until LINE_PIX pixels have been stored. All other writes are ignored.
- R5: Once a line is complete, it is shown from the next line-group start onward. Visible tick x of every visible line shows the x-th stored pixel, and this continues until a newer complete line replaces it.
- R6: Line groups are `rep_sel`+1 output lines long and restart at line 0 of every frame. The read side switches to a fresh line only at a group start, so a new line first appears on a frame line whose index is a multiple of `rep_sel`+1.
- R7: A capture that has not yet received all LINE_PIX pixels is never shown; the last complete line stays on screen.
- R8: With USE_PALETTE=1, a visible pixel with index i drives `rgb` to the palette entry i. Palette entries are loaded by `pal_we`/`pal_addr`/`pal_data` on `pix_clk`.
- R9: With USE_PALETTE=0, index bits {5:4,3:2,1:0} become `rgb` {11:8,7:4,3:0}, with each 2-bit field written twice within its nibble.
- R10: Outputs lag the timing counters by two `pix_clk` cycles. During reset and for the first two cycles after it, `hsync_n`=1, `vsync_n`=1 and `rgb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock, any rate |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| cpu_we | input | 1 | Output-port write strobe |
| cpu_data | input | 8 | Output-port byte: vsync, hsync, colour index |
| pix_clk | input | 1 | Pixel clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| rep_sel | input | 2 | Extra repeats of each line (0 to 3) |
| pal_we | input | 1 | Palette entry write strobe |
| pal_addr | input | 6 | Palette entry to write |
| pal_data | input | 12 | Colour for that entry |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |
| vsync_n | output | 1 | Regenerated vertical sync, active low |
| rgb | output | 12 | Pixel colour, 4 bits per channel |

## Verification
Sync and blanking outputs depend only on the pixel-domain counters. They are due exactly two `pix_clk` edges after the counter state that produces them. The bench therefore counts the edges since reset and compares every falling-edge sample against the position given by that count minus two.

Picture content depends on when the ready flag and the bank pointer cross domains. For that reason, the bench does not predict the cycle in which new content appears. It waits until pixel 0 of the new line shows up, checks that the line index lies on a group boundary, and then compares a whole later frame tick by tick.

// File: rtl/sl_pkg.sv
`timescale 1ns/1ps
package sl_pkg;
  localparam int PIX_W  = 8;
  localparam int IDX_W  = 6;
  localparam int RGB_W  = 12;
  localparam int VS_BIT = 7;
  localparam int HS_BIT = 6;

  typedef enum logic {CAP_FILL = 1'b0, CAP_HOLD = 1'b1} cap_state_t;

  function automatic logic [RGB_W-1:0] widen_idx(input logic [IDX_W-1:0] i);
    return {i[5:4], i[5:4], i[3:2], i[3:2], i[1:0], i[1:0]};
  endfunction
endpackage

// File: rtl/sl_sync2.sv
`timescale 1ns/1ps
module sl_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sl_capture.sv
`timescale 1ns/1ps
module sl_capture
  import sl_pkg::*;
#(
  parameter int LINE_PIX = 160,
  parameter int AW       = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PIX_W-1:0] data,
  input  logic             shown_bank_s,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic             line_rdy
);
  localparam int PW = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(LINE_PIX - 1);

  cap_state_t    state;
  logic          fill_bank;
  logic [PW-1:0] ptr;
  logic          prev_hs;
  logic          armed;

  logic hs_fall, is_pix, accept;
  assign hs_fall = we && !data[HS_BIT] && prev_hs;
  assign is_pix  = we && data[VS_BIT] && data[HS_BIT];
  assign accept  = is_pix && armed && (state == CAP_FILL);

  assign wr_en    = accept;
  assign wr_addr  = fill_bank ? (AW'(LINE_PIX) + AW'(ptr)) : AW'(ptr);
  assign wr_data  = data;
  assign line_rdy = (state == CAP_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_FILL;
      fill_bank <= 1'b1;
      ptr       <= '0;
      prev_hs   <= 1'b1;
      armed     <= 1'b0;
    end else begin
      if (we) prev_hs <= data[HS_BIT];
      case (state)
        CAP_FILL: begin
          if (hs_fall) begin
            ptr   <= '0;
            armed <= 1'b1;
          end else if (accept) begin
            if (ptr == PTR_LAST) begin
              state <= CAP_HOLD;
              armed <= 1'b0;
              ptr   <= '0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        CAP_HOLD: begin
          if (shown_bank_s == fill_bank) begin
            state     <= CAP_FILL;
            fill_bank <= ~fill_bank;
          end
        end
        default: state <= CAP_FILL;
      endcase
    end
  end

  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_LAST);

  assert_release_on_take_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == CAP_HOLD && state == CAP_FILL) |-> ($past(shown_bank_s) == $past(fill_bank)));

  assert_bank_flip_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(fill_bank) |-> ($past(state) == CAP_HOLD));
endmodule

// File: rtl/sl_linebuf.sv
`timescale 1ns/1ps
module sl_linebuf #(
  parameter int DEPTH = 320,
  parameter int AW    = 9,
  parameter int DW    = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sl_timing.sv
`timescale 1ns/1ps
module sl_timing #(
  parameter int LINE_PIX = 160,
  parameter int H_FP     = 4,
  parameter int H_SYNC   = 24,
  parameter int H_BP     = 12,
  parameter int V_VIS    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int AW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rep_sel,
  input  logic          line_rdy_s,
  output logic [AW-1:0] rd_addr,
  output logic          vis,
  output logic          hs_n,
  output logic          vs_n,
  output logic          rd_bank
);
  localparam int HT = LINE_PIX + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam logic [HW-1:0] H_LAST  = HW'(HT - 1);
  localparam logic [HW-1:0] H_VEND  = HW'(LINE_PIX);
  localparam logic [HW-1:0] HS_BEG  = HW'(LINE_PIX + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(LINE_PIX + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(VT - 1);
  localparam logic [VW-1:0] V_VEND  = VW'(V_VIS);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic [1:0]    rep_cnt;
  logic          took;

  logic line_end, frame_end, grp_start;
  assign line_end  = (h == H_LAST);
  assign frame_end = line_end && (v == V_LAST);
  assign grp_start = line_end && ((v == V_LAST) || (rep_cnt >= rep_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      h       <= '0;
      v       <= '0;
      rep_cnt <= '0;
      rd_bank <= 1'b0;
      took    <= 1'b0;
    end else begin
      h <= line_end ? '0 : h + 1'b1;
      if (line_end) begin
        v       <= (v == V_LAST) ? '0 : v + 1'b1;
        rep_cnt <= grp_start ? 2'd0 : rep_cnt + 2'd1;
      end
      if (!line_rdy_s) begin
        took <= 1'b0;
      end else if (grp_start && !took) begin
        rd_bank <= ~rd_bank;
        took    <= 1'b1;
      end
    end
  end

  assign vis     = (h < H_VEND) && (v < V_VEND);
  assign hs_n    = !((h >= HS_BEG) && (h < HS_END));
  assign vs_n    = !((v >= VS_BEG) && (v < VS_END));
  assign rd_addr = !vis ? '0 : (rd_bank ? (AW'(LINE_PIX) + AW'(h)) : AW'(h));

  assert_h_range_R1: assert property (@(posedge clk) disable iff (rst)
    h <= H_LAST);

  assert_v_range_R2: assert property (@(posedge clk) disable iff (rst)
    v <= V_LAST);

  assert_swap_at_group_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_bank) |-> $past(grp_start));

  assert_frame_realign_R6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (rep_cnt == 2'd0 && v == '0 && h == '0));
endmodule

// File: rtl/scanline_decoupler.sv
`timescale 1ns/1ps
module scanline_decoupler
  import sl_pkg::*;
#(
  parameter int LINE_PIX    = 160,
  parameter int H_FP        = 4,
  parameter int H_SYNC      = 24,
  parameter int H_BP        = 12,
  parameter int V_VIS       = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter bit USE_PALETTE = 1'b1
) (
  input  logic        cpu_clk,
  input  logic        cpu_rst,
  input  logic        cpu_we,
  input  logic [7:0]  cpu_data,
  input  logic        pix_clk,
  input  logic        pix_rst,
  input  logic [1:0]  rep_sel,
  input  logic        pal_we,
  input  logic [5:0]  pal_addr,
  input  logic [11:0] pal_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [11:0] rgb
);
  localparam int DEPTH = 2 * LINE_PIX;
  localparam int AW    = $clog2(DEPTH);

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [PIX_W-1:0] wr_data;
  logic             line_rdy, line_rdy_s;
  logic             rd_bank, shown_bank_s;
  logic [AW-1:0]    rd_addr;
  logic             vis0, hs0, vs0;
  logic [PIX_W-1:0] rdata;
  logic             vis1, hs1, vs1;
  logic [RGB_W-1:0] colour;

  sl_capture #(.LINE_PIX(LINE_PIX), .AW(AW)) cap_i (
    .clk(cpu_clk), .rst(cpu_rst), .we(cpu_we), .data(cpu_data),
    .shown_bank_s(shown_bank_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_rdy(line_rdy)
  );

  sl_sync2 #(.RST_VAL(1'b0)) rdy_sync_i (
    .clk(pix_clk), .rst(pix_rst), .d(line_rdy), .q(line_rdy_s)
  );

  sl_sync2 #(.RST_VAL(1'b0)) bank_sync_i (
    .clk(cpu_clk), .rst(cpu_rst), .d(rd_bank), .q(shown_bank_s)
  );

  sl_linebuf #(.DEPTH(DEPTH), .AW(AW), .DW(PIX_W)) buf_i (
    .wclk(cpu_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(pix_clk), .raddr(rd_addr), .rdata(rdata)
  );

  sl_timing #(
    .LINE_PIX(LINE_PIX), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .AW(AW)
  ) tim_i (
    .clk(pix_clk), .rst(pix_rst), .rep_sel(rep_sel), .line_rdy_s(line_rdy_s),
    .rd_addr(rd_addr), .vis(vis0), .hs_n(hs0), .vs_n(vs0), .rd_bank(rd_bank)
  );

  logic unused_sync_bits;
  assign unused_sync_bits = ^rdata[PIX_W-1:IDX_W];

  generate
    if (USE_PALETTE) begin : g_pal
      logic [RGB_W-1:0] pal_mem [64];
      always_ff @(posedge pix_clk) begin
        if (pal_we) pal_mem[pal_addr] <= pal_data;
      end
      assign colour = pal_mem[rdata[IDX_W-1:0]];
    end else begin : g_raw
      logic unused_pal_port;
      assign unused_pal_port = ^{pal_we, pal_addr, pal_data};
      assign colour = widen_idx(rdata[IDX_W-1:0]);
    end
  endgenerate

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      vis1    <= 1'b0;
      hs1     <= 1'b1;
      vs1     <= 1'b1;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      rgb     <= '0;
    end else begin
      vis1    <= vis0;
      hs1     <= hs0;
      vs1     <= vs0;
      hsync_n <= hs1;
      vsync_n <= vs1;
      rgb     <= vis1 ? colour : '0;
    end
  end

  assert_black_in_hsync_R3: assert property (@(posedge pix_clk) disable iff (pix_rst)
    !hsync_n |-> (rgb == '0));

  assert_black_in_vsync_R3: assert property (@(posedge pix_clk) disable iff (pix_rst)
    !vsync_n |-> (rgb == '0));
endmodule

// File: tb/scanline_decoupler_tb_top.sv
`timescale 1ns/1ps
module scanline_decoupler_tb_top;
  localparam int LP = 8, HFP = 2, HSY = 3, HBP = 2;
  localparam int VV = 6, VFP = 1, VSY = 2, VBP = 1;
  localparam int HT = LP + HFP + HSY + HBP;
  localparam int VT = VV + VFP + VSY + VBP;
  localparam int FT = HT * VT;

  logic        cpu_clk = 0, pix_clk = 0;
  logic        cpu_rst = 1, pix_rst = 1;
  logic        cpu_we = 0;
  logic [7:0]  cpu_data = 8'hC0;
  logic [1:0]  rep_sel = 0;
  logic        pal_we = 0;
  logic [5:0]  pal_addr = 0;
  logic [11:0] pal_data = 0;
  logic        hs, vs, hs_r, vs_r;
  logic [11:0] rgb, rgb_r;

  always #2 pix_clk = ~pix_clk;
  always #3.5 cpu_clk = ~cpu_clk;

  scanline_decoupler #(.LINE_PIX(LP), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .USE_PALETTE(1'b1)) dut_i (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_we(cpu_we), .cpu_data(cpu_data),
    .pix_clk(pix_clk), .pix_rst(pix_rst), .rep_sel(rep_sel), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_data(pal_data), .hsync_n(hs), .vsync_n(vs), .rgb(rgb));

  scanline_decoupler #(.LINE_PIX(LP), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .USE_PALETTE(1'b0)) dut_raw_i (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_we(cpu_we), .cpu_data(cpu_data),
    .pix_clk(pix_clk), .pix_rst(pix_rst), .rep_sel(rep_sel), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_data(pal_data), .hsync_n(hs_r), .vsync_n(vs_r), .rgb(rgb_r));

  int checks = 0, errs = 0;
  int pcount = 0, wd = 0;
  bit mon_on = 0, done = 0;

  function automatic int idxf(int k, int x); return (k * 11 + x * 5 + 1) & 63; endfunction
  function automatic int palf(int i); return (i * 73 + 19) & 12'hFFF; endfunction
  function automatic int widf(int i);
    int r = (i >> 4) & 3, g = (i >> 2) & 3, b = i & 3;
    return (((r << 2) | r) << 8) | (((g << 2) | g) << 4) | ((b << 2) | b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge pix_clk) begin
    if (pix_rst) pcount <= 0; else pcount <= pcount + 1;
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      done = 1;
      chk(0, "watchdog (all)", wd, 100000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // continuous timing monitor: R1, R2, R3, R10
  always @(negedge pix_clk) begin
    if (mon_on) begin
      if (pix_rst || pcount < 2) begin
        chk(hs && vs && hs_r && vs_r && rgb == 0 && rgb_r == 0, "R10 reset state",
            {hs, vs, rgb}, {2'b11, 12'h0});
      end else begin
        int p, h, v;
        bit ehs, evs;
        p = pcount - 2;
        h = p % HT;
        v = (p / HT) % VT;
        ehs = !(h >= LP + HFP && h < LP + HFP + HSY);
        evs = !(v >= VV + VFP && v < VV + VFP + VSY);
        chk(hs == ehs && hs_r == ehs, "R1 hsync", hs, ehs);
        chk(vs == evs && vs_r == evs, "R2 vsync", vs, evs);
        if (!(h < LP && v < VV))
          chk(rgb == 0 && rgb_r == 0, "R3 blanking", rgb | rgb_r, 0);
      end
    end
  end

  task automatic cpu_wr(input logic [7:0] b);
    @(negedge cpu_clk); cpu_we = 1; cpu_data = b;
    @(negedge cpu_clk); cpu_we = 0;
  endtask

  task automatic write_line(input int k, input int n);
    cpu_wr(8'hC0);
    cpu_wr(8'h80);                 // hsync falls: line start
    cpu_wr(8'h80 | 8'(idxf(k + 40, 0)));   // sync write, ignored
    for (int x = 0; x < n; x++) begin
      if (x == 3) cpu_wr(8'h40 | 8'(idxf(k + 50, 3)));  // vsync low, ignored
      cpu_wr(8'hC0 | 8'(idxf(k, x)));
    end
    cpu_wr(8'hC0);
  endtask

  task automatic wait_new(input int k, output int ln);
    int t = 0;
    ln = -1;
    while (ln < 0 && t < 3000) begin
      int p;
      @(negedge pix_clk);
      t++;
      p = pcount - 2;
      if (p >= 0 && (p % HT) == 0 && ((p / HT) % VT) < VV && int'(rgb) == palf(idxf(k, 0)))
        ln = (p / HT) % VT;
    end
    chk(ln >= 0, "R5 line appears", ln, 0);
  endtask

  task automatic check_frame(input int k, input string tag);
    int bad = 0, bad_r = 0, a = 0, e = 0, ar = 0, er = 0;
    do @(negedge pix_clk); while (!(pcount >= 2 && ((pcount - 2) % FT) == FT - 1));
    for (int pp = 0; pp < FT; pp++) begin
      int h, v;
      @(negedge pix_clk);
      h = pp % HT;
      v = pp / HT;
      if (h < LP && v < VV) begin
        if (int'(rgb) != palf(idxf(k, h))) begin
          if (bad == 0) begin a = rgb; e = palf(idxf(k, h)); end
          bad++;
        end
        if (int'(rgb_r) != widf(idxf(k, h))) begin
          if (bad_r == 0) begin ar = rgb_r; er = widf(idxf(k, h)); end
          bad_r++;
        end
      end
    end
    chk(bad == 0, {tag, " R8 palette frame"}, a, e);
    chk(bad_r == 0, {tag, " R9 widened frame"}, ar, er);
  endtask

  task automatic wait_pix(input int n);
    repeat (n) @(negedge pix_clk);
  endtask

  initial begin
    int ln;
    mon_on = 0;
    repeat (2) @(negedge pix_clk);
    mon_on = 1;
    repeat (4) @(negedge pix_clk);
    cpu_rst = 0;
    pix_rst = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge pix_clk);
      pal_we = 1; pal_addr = 6'(i); pal_data = 12'(palf(i));
    end
    @(negedge pix_clk); pal_we = 0;

    // R4 R5 R6: each repeat setting, fresh line appears on a group boundary
    for (int r = 0; r < 4; r++) begin
      @(negedge pix_clk); rep_sel = 2'(r);
      wait_pix(FT + 10);
      write_line(r + 1, LP);
      wait_new(r + 1, ln);
      chk(ln >= 0 && (ln % (r + 1)) == 0, "R6 group boundary", ln, 0);
      check_frame(r + 1, "R4 R5");
    end

    // R7: partial capture is never shown, last complete line stays
    write_line(5, LP / 2);
    wait_pix(4 * FT);
    check_frame(4, "R7 partial ignored");

    // R4: a new line start after a partial one restarts at pixel 0
    @(negedge pix_clk); rep_sel = 2'd1;
    wait_pix(FT + 10);
    write_line(6, LP);
    wait_new(6, ln);
    chk(ln >= 0 && (ln % 2) == 0, "R6 group boundary after partial", ln, 0);
    check_frame(6, "R4 restart");

    wait_pix(20);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule